// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This engine runs on the host side of a parallel NOR flash. It decides when an embedded program or erase operation has finished. A caller hands it one operation over a valid/ready command channel. The operation carries its type (program or erase), the target address and, for a program, the byte being written. The engine then waits for the caller to report that the final write strobe of the command sequence has risen. After that it issues status reads through a one-at-a-time read port, with a configurable idle gap between reads.

Each status read is judged on its top bit only. While a program is running, that bit reads as the complement of the top bit being written. While an erase is running, it reads 0. The operation is over once the bit reads as the written top bit (program) or 1 (erase). The top bit can settle before the lower bits do, so a match does not end the operation. The engine issues one further full read, and that confirming read alone decides pass or fail: the whole byte must equal the written byte for a program, or be all ones for an erase. If the top bit never matches within a cycle limit, the engine reports a failure with a timeout flag. The result is offered on a valid/ready result channel.

Back-pressure rules:
- The command channel accepts only while the engine is idle.
- A read request holds its valid and its address until the read port raises ready.
- Read responses carry no ready. The engine always takes a response while a read is outstanding, and a response must arrive at least one cycle after its request handshake.
- The result stays valid and unchanged until the consumer raises ready.

Top module: `dpoll_engine`

## Requirements
- R1: After reset the engine is idle: cmd_ready is 1, rd_req_valid is 0 and done_valid is 0.
- R2: After a command is accepted, no read request is raised until seq_done has been seen high.
- R3: Every read request carries the address latched from the accepted command. While rd_req_ready is low, rd_req_valid and rd_addr hold.
- R4: For a program (cmd_erase=0), a status read whose bit 7 differs from bit 7 of cmd_data is treated as busy and leads to another status read.
- R5: For an erase (cmd_erase=1), a status read with bit 7 equal to 0 is busy. Bit 7 equal to 1 counts as a match.
- R6: After a matching read, exactly one confirming read follows. For a program, done_pass is 1 only if that read equals cmd_data in all 8 bits. For an erase, it must equal 8'hFF.
- R7: Bits 6..0 of the matching read do not affect the result; only the confirming read does.
- R8: At most one read is outstanding. No new request is raised between a request handshake and its response.
- R9: Between a response and the next read request, at least cfg_gap idle cycles pass (cfg_gap is sampled when the command is accepted).
- R10: If a busy status read returns once cfg_timeout or more cycles have passed since polling began, the engine ends with done_pass=0 and done_timeout=1.
- R11: done_valid, done_pass and done_timeout hold until done_ready. cmd_ready stays 0 from command acceptance until the result handshake, so commands offered meanwhile are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid (idle only) |
| cmd_erase | input | 1 | 1 = erase operation, 0 = program operation |
| cmd_addr | input | AW | Program address, or an address inside a sector being erased |
| cmd_data | input | DW | Byte being programmed (unused for erase) |
| cfg_gap | input | GW | Minimum idle cycles between reads, sampled at accept |
| cfg_timeout | input | TW | Polling cycle limit, sampled at accept |
| seq_done | input | 1 | Final write strobe of the command sequence has risen |
| rd_req_valid | output | 1 | Read request |
| rd_req_ready | input | 1 | Read port takes the request |
| rd_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | DW | Read data |
| done_valid | output | 1 | Result available |
| done_ready | input | 1 | Result consumed |
| done_pass | output | 1 | Operation completed with the expected content |
| done_timeout | output | 1 | Polling gave up at the cycle limit |

## Verification
A stuck or wrong phase in the engine shows at the read port within one request. Examples are a request before seq_done, a second request while one is outstanding, a request that comes too soon after a response, or an address that differs from the command's. A wrong match or confirm decision surfaces at the next result handshake: done_pass or done_timeout differs from the value predicted from the scripted response sequence. Scenarios place a settled top bit over unsettled low bits on the matching read, so that judging the byte too early shows as a wrong pass.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_POLL,
    ST_CONF,
    ST_DONE
  } dp_state_e;

  typedef enum logic [1:0] {
    PH_GAP,
    PH_REQ,
    PH_RSP
  } dp_phase_e;
endpackage

// File: rtl/dpoll_gap.sv
// Down-counter enforcing idle cycles between reads.
module dpoll_gap #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          zero_o
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/dpoll_tmo.sv
// Saturating polling-time counter with limit compare.
module dpoll_tmo #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired_o
);
  localparam logic [TW-1:0] CMAX = '1;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (run && cnt != CMAX)  cnt <= cnt + 1'b1;
  end

  assign expired_o = (cnt >= limit);
endmodule

// File: rtl/dpoll_judge.sv
// Status-bit and full-byte evaluation of a read.
module dpoll_judge #(
  parameter int DW = 8
) (
  input  logic          erase,
  input  logic [DW-1:0] exp_data,
  input  logic [DW-1:0] rsp_data,
  output logic          top_ok,
  output logic          byte_ok
);
  localparam int SB = DW - 1;
  logic want_top;

  always_comb begin
    want_top = erase | exp_data[SB];
    top_ok   = (rsp_data[SB] == want_top);
    byte_ok  = erase ? (&rsp_data) : (rsp_data == exp_data);
  end
endmodule

// File: rtl/dpoll_engine.sv
module dpoll_engine
  import dpoll_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter int GW = 8,
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_erase,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [GW-1:0] cfg_gap,
  input  logic [TW-1:0] cfg_timeout,
  input  logic          seq_done,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          done_valid,
  input  logic          done_ready,
  output logic          done_pass,
  output logic          done_timeout
);
  dp_state_e     state;
  dp_phase_e     phase;
  logic          erase_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [GW-1:0] gap_q;
  logic [TW-1:0] tmo_q;
  logic          pass_q;
  logic          tflag_q;

  logic gap_zero, expired, top_ok, byte_ok;
  logic polling, in_rsp, gap_load, tmo_clr, tmo_run;

  always_comb begin
    polling  = (state == ST_POLL) || (state == ST_CONF);
    in_rsp   = polling && (phase == PH_RSP);
    gap_load = in_rsp && rd_rsp_valid;
    tmo_clr  = (state == ST_WAIT);
    tmo_run  = (state == ST_POLL);
  end

  dpoll_gap #(.GW(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_q), .zero_o(gap_zero)
  );

  dpoll_tmo #(.TW(TW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .run(tmo_run), .limit(tmo_q),
    .expired_o(expired)
  );

  dpoll_judge #(.DW(DW)) u_judge (
    .erase(erase_q), .exp_data(data_q), .rsp_data(rd_rsp_data),
    .top_ok(top_ok), .byte_ok(byte_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_GAP;
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      gap_q   <= '0;
      tmo_q   <= '0;
      pass_q  <= 1'b0;
      tflag_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          erase_q <= cmd_erase;
          addr_q  <= cmd_addr;
          data_q  <= cmd_data;
          gap_q   <= cfg_gap;
          tmo_q   <= cfg_timeout;
          state   <= ST_WAIT;
        end
        ST_WAIT: if (seq_done) begin
          state <= ST_POLL;
          phase <= PH_REQ;
        end
        ST_POLL, ST_CONF: begin
          case (phase)
            PH_GAP: if (gap_zero) phase <= PH_REQ;
            PH_REQ: if (rd_req_ready) phase <= PH_RSP;
            PH_RSP: if (rd_rsp_valid) begin
              if (state == ST_CONF) begin
                pass_q  <= byte_ok;
                tflag_q <= 1'b0;
                state   <= ST_DONE;
              end else if (top_ok) begin
                state <= ST_CONF;
                phase <= PH_GAP;
              end else if (expired) begin
                pass_q  <= 1'b0;
                tflag_q <= 1'b1;
                state   <= ST_DONE;
              end else begin
                phase <= PH_GAP;
              end
            end
            default: phase <= PH_GAP;
          endcase
        end
        ST_DONE: if (done_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (state == ST_IDLE);
  assign rd_req_valid = polling && (phase == PH_REQ);
  assign rd_addr      = addr_q;
  assign done_valid   = (state == ST_DONE);
  assign done_pass    = pass_q;
  assign done_timeout = tflag_q;
endmodule

// File: rtl/dpoll_engine_chk.sv
module dpoll_engine_chk #(
  parameter int AW = 24,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [GW-1:0] cfg_gap,
  input logic          seq_done,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_addr,
  input logic          rd_rsp_valid,
  input logic          done_valid,
  input logic          done_ready,
  input logic          done_pass,
  input logic          done_timeout
);
  localparam logic [GW:0] GMAX = '1;
  logic          busy, armed, outstanding, seen_rsp;
  logic [GW-1:0] gap_l;
  logic [GW:0]   gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; armed <= 1'b0; outstanding <= 1'b0; seen_rsp <= 1'b0;
      gap_l <= '0; gcnt <= '0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        busy <= 1'b1; gap_l <= cfg_gap; seen_rsp <= 1'b0;
      end else if (done_valid && done_ready) begin
        busy <= 1'b0; armed <= 1'b0;
      end else if (busy && seq_done) begin
        armed <= 1'b1;
      end
      if (rd_req_valid && rd_req_ready) outstanding <= 1'b1;
      else if (rd_rsp_valid)            outstanding <= 1'b0;
      if (rd_rsp_valid) begin
        gcnt <= '0; seen_rsp <= 1'b1;
      end else if (gcnt != GMAX) begin
        gcnt <= gcnt + 1'b1;
      end
    end
  end

  a_r2_no_early_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> armed);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !rd_req_valid);
  a_r9_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) && seen_rsp |-> gcnt >= {1'b0, gap_l});
  a_r10_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_timeout |-> !done_pass);
  a_r11_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid && $stable(done_pass) && $stable(done_timeout));
endmodule

bind dpoll_engine dpoll_engine_chk #(.AW(AW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cfg_gap(cfg_gap), .seq_done(seq_done), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
  .done_valid(done_valid), .done_ready(done_ready), .done_pass(done_pass),
  .done_timeout(done_timeout)
);

// File: tb/dpoll_engine_bench.sv
module dpoll_engine_bench;
  localparam int AW = 24, DW = 8, GW = 8, TW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_erase = 1'b0, seq_done = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [GW-1:0] cfg_gap = '0;
  logic [TW-1:0] cfg_timeout = '0;
  logic rd_req_ready, rd_rsp_valid, done_ready = 1'b0;
  logic [DW-1:0] rd_rsp_data;
  logic cmd_ready, rd_req_valid, done_valid, done_pass, done_timeout;
  logic [AW-1:0] rd_addr;

  always #5 clk = ~clk;

  dpoll_engine #(.AW(AW), .DW(DW), .GW(GW), .TW(TW)) u_dpoll_engine (.*);

  int total = 0, bad = 0, cyc = 0, done_cnt = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];

  // model of the current operation
  logic m_erase; logic [DW-1:0] m_data, m_final; logic [AW-1:0] m_addr;
  int m_busy, m_skew, m_lat, m_stall, m_gap;
  int read_idx = 0, req_cnt = 0, rsp_cyc = 0;
  bit have_rsp = 0, outstanding = 0, prev_req = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input int k);
    logic [6:0] junk = 7'h55 ^ 7'(k);
    if (k < m_busy)          return m_erase ? {1'b0, junk} : {~m_data[7], junk};
    if (k < m_busy + m_skew) return m_erase ? {1'b1, 7'h00} : {m_data[7], ~m_data[6:0]};
    return m_final;
  endfunction

  // read-port responder
  initial begin
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rd_req_valid) begin
        for (int s = 0; s < m_stall; s++) begin
          chk(rd_addr == m_addr, "R3 addr while stalled", int'(rd_addr), int'(m_addr));
          @(negedge clk);
          chk(rd_req_valid == 1'b1, "R3 request held", int'(rd_req_valid), 1);
        end
        chk(rd_addr == m_addr, "R3 addr", int'(rd_addr), int'(m_addr));
        rd_req_ready = 1;
        @(negedge clk);
        rd_req_ready = 0; req_cnt++; outstanding = 1;
        for (int l = 1; l < m_lat; l++) @(negedge clk);
        rd_rsp_valid = 1; rd_rsp_data = model(read_idx); read_idx++;
        @(negedge clk);
        rd_rsp_valid = 0; outstanding = 0;
      end
    end
  end

  // port monitor: outstanding and gap
  initial forever begin
    @(negedge clk);
    if (outstanding && rd_req_valid) chk(0, "R8 request while outstanding", 1, 0);
    if (rd_rsp_valid) begin rsp_cyc = cyc; have_rsp = 1; end
    if (rd_req_valid && !prev_req && have_rsp)
      chk(cyc - rsp_cyc - 1 >= m_gap, "R9 gap", cyc - rsp_cyc - 1, m_gap);
    prev_req = rd_req_valid;
  end

  // result monitor / scoreboard
  initial begin
    int hold = 0;
    forever begin
      @(negedge clk);
      if (done_valid && !done_ready) begin
        hold++;
        chk(cmd_ready == 1'b0, "R11 no accept while result pending", int'(cmd_ready), 0);
        if (hold == 3) begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(done_pass == e[1], "R6 pass", int'(done_pass), int'(e[1]));
          chk(done_timeout == e[0], "R10 timeout flag", int'(done_timeout), int'(e[0]));
          done_ready = 1;
        end
      end else if (done_ready) begin
        done_ready = 0; hold = 0; done_cnt++;
      end
    end
  end

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int busy, input int skew, input logic [DW-1:0] fin,
                        input int gap, input int tmo, input int lat, input int stall,
                        input int sdly, input bit poke, input bit ep, input bit et);
    int target;
    m_erase = er; m_addr = a; m_data = d; m_busy = busy; m_skew = skew; m_final = fin;
    m_gap = gap; m_lat = lat; m_stall = stall;
    read_idx = 0; req_cnt = 0; have_rsp = 0;
    exp_q.push_back({ep, et});
    target = done_cnt + 1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 idle before command", int'(cmd_ready), 1);
    cmd_valid = 1; cmd_erase = er; cmd_addr = a; cmd_data = d;
    cfg_gap = GW'(gap); cfg_timeout = TW'(tmo);
    @(negedge clk);
    cmd_valid = 0;
    repeat (sdly) @(negedge clk);
    chk(req_cnt == 0 && !rd_req_valid, "R2 no read before seq_done", req_cnt, 0);
    seq_done = 1;
    @(negedge clk);
    seq_done = 0;
    if (poke) begin
      for (int p = 0; p < 3; p++) begin
        cmd_valid = 1; cmd_data = ~d; cmd_addr = ~a;
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R11 command ignored while busy", int'(cmd_ready), 0);
      end
      cmd_valid = 0;
    end
    while (done_cnt < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
    chk(rd_req_valid == 1'b0, "R1 rd_req_valid", int'(rd_req_valid), 0);
    chk(done_valid == 1'b0, "R1 done_valid", int'(done_valid), 0);
    // R4 program, three busy reads, then correct byte
    run_op(0, 24'h012345, 8'hA5, 3, 0, 8'hA5, 1, 5000, 1, 0, 4, 0, 1, 0);
    // R4 program already complete, top bit 0
    run_op(0, 24'h000010, 8'h3C, 0, 0, 8'h3C, 0, 5000, 2, 1, 0, 0, 1, 0);
    // R5 erase, four busy reads, poke commands while busy (R11)
    run_op(1, 24'h7F0000, 8'h00, 4, 0, 8'hFF, 2, 5000, 1, 0, 2, 1, 1, 0);
    // R7 erase, matching read has junk low bits, confirm is 0xFF
    run_op(1, 24'h100000, 8'h00, 2, 1, 8'hFF, 0, 5000, 1, 1, 1, 0, 1, 0);
    // R7 program, two skewed reads: confirm sees junk -> fail
    run_op(0, 24'h0ABCDE, 8'h96, 2, 2, 8'h96, 1, 5000, 1, 0, 1, 0, 0, 0);
    // R6 program final byte differs in low bits -> fail
    run_op(0, 24'h000200, 8'h81, 1, 0, 8'h80, 0, 5000, 1, 0, 1, 0, 0, 0);
    // R6 erase final 0xFE -> fail
    run_op(1, 24'h200000, 8'h00, 1, 0, 8'hFE, 0, 5000, 1, 0, 1, 0, 0, 0);
    // R10 never completes -> timeout
    run_op(0, 24'h000300, 8'h11, 100000, 0, 8'h11, 2, 50, 1, 0, 1, 0, 0, 1);
    // R9 long gap with back-pressure and latency
    run_op(1, 24'h300000, 8'h00, 3, 0, 8'hFF, 5, 5000, 3, 2, 3, 0, 1, 0);
    // R1 idle again after last handshake
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 idle after result", int'(cmd_ready), 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, 9);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule